// File: doc/BRIEF.md
# Segmented Principal Component Projection Unit

This block produces the neuron outputs of a Hebbian principal-component learner. For each neuron j it forms y_j as the dot product of that neuron's weight vector with the current training vector. The vectors have M = Q·B elements. The block does not process them in one wide pass. It walks each vector as B segments of Q elements, one segment per clock, through Q multipliers, a registered adder tree and a wide accumulator. The datapath width therefore depends on Q and not on M.

A training vector first arrives over a Q-element load port, one segment per beat. The beats are stored in Q lane banks. The weights live in an internal two-port RAM: the projection reads it, and the external weight-update logic writes it through a dedicated write port. Each finished y_j goes to the update logic over a valid/ready handshake. The projection then moves straight on to neuron j+1 while neuron j's new weights are written back. After the last neuron the block raises a done flag. It waits for the update side to declare the iteration finished before it accepts the next vector.

Top module: `seg_proj_unit`

## Requirements
- R1: A load beat k (beats 0..B-1 of a vector) carries element k·Q+r in lane r (bits r·DW +: DW). A weight word written at (neuron j, segment k) holds w_j element k·Q+r in lane r. Elements are signed two's complement. The output is y_j = floor((Σ w_j[e]·x[e] + 2^(FRAC-1)) / 2^FRAC), clamped to a signed YW-bit range.
- R2: Within one iteration the outputs come out in neuron order 0..P-1, and y_neuron carries the index of the value on y_data.
- R3: A sum whose rounded value lies outside the signed YW-bit range saturates to +2^(YW-1)-1 or -2^(YW-1).
- R4: Rounding is half toward plus infinity at the FRAC fraction position. For example, with FRAC=12, raw sums 2048, -2048, 2047 and -2049 give 1, 0, 0 and -1.
- R5: While y_valid is high and y_ready is low, y_data and y_neuron hold steady. Under any back-pressure no result is lost or altered.
- R6: ld_ready is high only while the unit waits for a vector. Load beats offered while it is low are ignored.
- R7: Weight writes to neuron j after y_j has been taken do not change any output of the current iteration. They apply from the next iteration onward.
- R8: done rises in the cycle after the handshake of neuron P-1 and stays high until iter_done is sampled high. ld_ready is high in the following cycle. iter_done at any other time has no effect.
- R9: After reset, ld_ready is 1, y_valid is 0 and done is 0.
- R10: With y_ready held high, successive outputs of one iteration appear exactly B cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Unit accepts load beats |
| ld_data | input | Q*DW | One Q-element segment of the training vector |
| wr_en | input | 1 | Weight RAM write strobe |
| wr_neuron | input | JW | Neuron index of the written segment |
| wr_seg | input | KW | Segment index of the written segment |
| wr_data | input | Q*DW | Q weight elements |
| y_valid | output | 1 | Output value present |
| y_ready | input | 1 | Update side takes the output |
| y_data | output | YW | Rounded, saturated projection |
| y_neuron | output | JW | Neuron index of y_data |
| done | output | 1 | All P outputs of the iteration delivered |
| iter_done | input | 1 | Update side finished the iteration |

## Verification
The bench targets these corner cases and the failure each one would reveal:
- Exact half-LSB sums of both signs: a design that truncates, or rounds half away from zero, returns a value off by one.
- Sums far beyond the output range: a design that wraps instead of clamping flips the sign.
- Long random stalls on y_ready, with new weights written for the neuron just taken: a design with a broken stall drops or repeats a neuron, and one whose reads race the writes mixes next-iteration weights into the current outputs.
- Stray load beats and iter_done pulses during a run: a design that does not guard them corrupts the held vector or ends the iteration early.
- Output spacing with y_ready held high: a pipeline that does not overlap neurons spaces the outputs more than B cycles apart.

// File: rtl/spu_pkg.sv
package spu_pkg;

   typedef enum logic [1:0] {
      ST_LOAD  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } spu_state_t;

   function automatic int safe_clog2(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

endpackage

// File: rtl/spu_input_bank.sv
module spu_input_bank #(
   parameter int Q  = 4,
   parameter int B  = 4,
   parameter int DW = 16,
   parameter int KW = 2
) (
   input  logic            clk,
   input  logic            wen,
   input  logic [KW-1:0]   widx,
   input  logic [Q*DW-1:0] wdata,
   input  logic            ren,
   input  logic [KW-1:0]   ridx,
   output logic [Q*DW-1:0] rdata
);

   for (genvar r = 0; r < Q; r++) begin : g_lane
      logic [DW-1:0] cells [B];
      logic [DW-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (wen) cells[widx] <= wdata[r*DW +: DW];
         if (ren) rd_q <= cells[ridx];
      end

      assign rdata[r*DW +: DW] = rd_q;
   end

endmodule

// File: rtl/spu_weight_ram.sv
module spu_weight_ram #(
   parameter int WIDTH = 64,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/spu_dot_seg.sv
module spu_dot_seg #(
   parameter int Q            = 4,
   parameter int DW           = 16,
   parameter int ACCW         = 37,
   parameter int TW           = 4,
   parameter bit REG_PRODUCTS = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic                   in_v,
   input  logic [TW-1:0]          in_tag,
   input  logic [Q*DW-1:0]        x_seg,
   input  logic [Q*DW-1:0]        w_seg,
   output logic                   out_v,
   output logic [TW-1:0]          out_tag,
   output logic signed [ACCW-1:0] out_sum
);

   localparam int PW = 2 * DW;
   localparam int QP = 1 << $clog2(Q);

   logic signed [PW-1:0]   prod_c [Q];
   logic signed [PW-1:0]   prod_m [Q];
   logic                   m_v;
   logic [TW-1:0]          m_tag;
   logic signed [ACCW-1:0] node [2*QP-1];

   for (genvar r = 0; r < Q; r++) begin : g_mul
      assign prod_c[r] = $signed(x_seg[r*DW +: DW]) * $signed(w_seg[r*DW +: DW]);
   end

   if (REG_PRODUCTS) begin : g_preg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            m_v <= 1'b0;
         end else if (en) begin
            m_v <= in_v;
         end
      end
      always_ff @(posedge clk) begin
         if (en) begin
            m_tag <= in_tag;
            for (int r = 0; r < Q; r++) prod_m[r] <= prod_c[r];
         end
      end
   end else begin : g_pcomb
      assign m_v   = in_v;
      assign m_tag = in_tag;
      for (genvar r = 0; r < Q; r++) begin : g_pass
         assign prod_m[r] = prod_c[r];
      end
   end

   for (genvar l = 0; l < QP; l++) begin : g_leaf
      if (l < Q) begin : g_used
         assign node[QP-1+l] = {{(ACCW-PW){prod_m[l][PW-1]}}, prod_m[l]};
      end else begin : g_pad
         assign node[QP-1+l] = '0;
      end
   end

   for (genvar n = 0; n < QP - 1; n++) begin : g_tree
      assign node[n] = node[2*n+1] + node[2*n+2];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v <= 1'b0;
      end else if (en) begin
         out_v <= m_v;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         out_tag <= m_tag;
         out_sum <= node[0];
      end
   end

endmodule

// File: rtl/seg_proj_unit.sv
module seg_proj_unit
   import spu_pkg::*;
#(
   parameter int Q            = 4,
   parameter int B            = 4,
   parameter int P            = 4,
   parameter int DW           = 16,
   parameter int YW           = 16,
   parameter int FRAC         = 12,
   parameter bit REG_PRODUCTS = 1'b1,
   localparam int JW          = safe_clog2(P),
   localparam int KW          = safe_clog2(B)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_valid,
   output logic            ld_ready,
   input  logic [Q*DW-1:0] ld_data,
   input  logic            wr_en,
   input  logic [JW-1:0]   wr_neuron,
   input  logic [KW-1:0]   wr_seg,
   input  logic [Q*DW-1:0] wr_data,
   output logic            y_valid,
   input  logic            y_ready,
   output logic [YW-1:0]   y_data,
   output logic [JW-1:0]   y_neuron,
   output logic            done,
   input  logic            iter_done
);

   localparam int LANEW = Q * DW;
   localparam int DEPTH = P * B;
   localparam int AW    = safe_clog2(DEPTH);
   localparam int ACCW  = 2 * DW + $clog2(Q * B) + 1;
   localparam int TW    = JW + 2;
   localparam logic signed [ACCW:0] HALF = (ACCW+1)'(1) << (FRAC - 1);
   localparam logic signed [ACCW:0] YMAX = (ACCW+1)'((64'sd1 <<< (YW - 1)) - 64'sd1);
   localparam logic signed [ACCW:0] YMIN = -YMAX - (ACCW+1)'(1);

   if (Q < 1 || B < 1 || P < 1) begin : g_bad_dims
      $error("seg_proj_unit: Q, B and P must all be at least 1");
   end
   if (DW < 2 || YW < 2 || YW > 32) begin : g_bad_width
      $error("seg_proj_unit: DW must be >= 2 and YW within 2..32");
   end
   if (FRAC < 1 || FRAC + YW > ACCW) begin : g_bad_frac
      $error("seg_proj_unit: FRAC must be >= 1 and leave room for YW in the accumulator");
   end

   spu_state_t             state;
   logic [KW-1:0]          ld_cnt;
   logic [JW-1:0]          j_cnt;
   logic [KW-1:0]          k_cnt;
   logic                   ld_fire;
   logic                   issue;
   logic                   adv;
   logic                   wr_ok;
   logic [AW-1:0]          wr_addr;
   logic [AW-1:0]          rd_addr;
   logic                   rd_v;
   logic [TW-1:0]          rd_tag;
   logic [LANEW-1:0]       x_seg;
   logic [LANEW-1:0]       w_seg;
   logic                   s_v;
   logic [TW-1:0]          s_tag;
   logic signed [ACCW-1:0] s_sum;
   logic                   s_first;
   logic                   s_last;
   logic [JW-1:0]          s_j;
   logic signed [ACCW-1:0] acc;
   logic signed [ACCW-1:0] acc_nx;
   logic signed [ACCW:0]   rnd;
   logic signed [ACCW:0]   shf;
   logic [YW-1:0]          y_nx;
   logic                   last_taken;

   assign ld_ready = (state == ST_LOAD);
   assign done     = (state == ST_DONE);
   assign ld_fire  = ld_valid && ld_ready;
   assign issue    = (state == ST_RUN);

   assign wr_ok   = wr_en && (int'(wr_neuron) < P) && (int'(wr_seg) < B);
   assign wr_addr = AW'(int'(wr_neuron) * B + int'(wr_seg));
   assign rd_addr = AW'(int'(j_cnt) * B + int'(k_cnt));

   spu_input_bank #(.Q(Q), .B(B), .DW(DW), .KW(KW)) u_bank (
      .clk   (clk),
      .wen   (ld_fire),
      .widx  (ld_cnt),
      .wdata (ld_data),
      .ren   (adv),
      .ridx  (k_cnt),
      .rdata (x_seg)
   );

   spu_weight_ram #(.WIDTH(LANEW), .DEPTH(DEPTH), .AW(AW)) u_wram (
      .clk   (clk),
      .we    (wr_ok),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (adv),
      .raddr (rd_addr),
      .rdata (w_seg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_v   <= 1'b0;
         rd_tag <= '0;
      end else if (adv) begin
         rd_v   <= issue;
         rd_tag <= {k_cnt == '0, k_cnt == KW'(B - 1), j_cnt};
      end
   end

   spu_dot_seg #(
      .Q(Q), .DW(DW), .ACCW(ACCW), .TW(TW), .REG_PRODUCTS(REG_PRODUCTS)
   ) u_dot (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (adv),
      .in_v    (rd_v),
      .in_tag  (rd_tag),
      .x_seg   (x_seg),
      .w_seg   (w_seg),
      .out_v   (s_v),
      .out_tag (s_tag),
      .out_sum (s_sum)
   );

   assign s_first = s_tag[TW-1];
   assign s_last  = s_tag[TW-2];
   assign s_j     = s_tag[JW-1:0];

   // The whole pipeline freezes only when a finished result meets an untaken one.
   assign adv = !(s_v && s_last && y_valid && !y_ready);

   always_comb begin
      acc_nx = (s_first ? '0 : acc) + s_sum;
      rnd    = $signed({acc_nx[ACCW-1], acc_nx}) + HALF;
      shf    = rnd >>> FRAC;
      if (shf > YMAX)      y_nx = YMAX[YW-1:0];
      else if (shf < YMIN) y_nx = YMIN[YW-1:0];
      else                 y_nx = shf[YW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc      <= '0;
         y_valid  <= 1'b0;
         y_data   <= '0;
         y_neuron <= '0;
      end else begin
         if (adv && s_v) acc <= acc_nx;
         if (adv && s_v && s_last) begin
            y_valid  <= 1'b1;
            y_data   <= y_nx;
            y_neuron <= s_j;
         end else if (y_valid && y_ready) begin
            y_valid <= 1'b0;
         end
      end
   end

   assign last_taken = y_valid && y_ready && (y_neuron == JW'(P - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_LOAD;
         ld_cnt <= '0;
         j_cnt  <= '0;
         k_cnt  <= '0;
      end else begin
         case (state)
            ST_LOAD: begin
               if (ld_fire) begin
                  if (ld_cnt == KW'(B - 1)) begin
                     ld_cnt <= '0;
                     j_cnt  <= '0;
                     k_cnt  <= '0;
                     state  <= ST_RUN;
                  end else begin
                     ld_cnt <= ld_cnt + 1'b1;
                  end
               end
            end
            ST_RUN: begin
               if (adv) begin
                  if (k_cnt == KW'(B - 1)) begin
                     k_cnt <= '0;
                     if (j_cnt == JW'(P - 1)) state <= ST_DRAIN;
                     else                     j_cnt <= j_cnt + 1'b1;
                  end else begin
                     k_cnt <= k_cnt + 1'b1;
                  end
               end
            end
            ST_DRAIN: begin
               if (last_taken) state <= ST_DONE;
            end
            default: begin
               if (iter_done) state <= ST_LOAD;
            end
         endcase
      end
   end

endmodule

// File: rtl/spu_checker.sv
module spu_checker #(
   parameter int P  = 4,
   parameter int JW = 2,
   parameter int YW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ld_ready,
   input logic          y_valid,
   input logic          y_ready,
   input logic [YW-1:0] y_data,
   input logic [JW-1:0] y_neuron,
   input logic          done,
   input logic          iter_done
);

   logic [JW-1:0] next_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_idx <= '0;
      end else if (y_valid && y_ready) begin
         next_idx <= (next_idx == JW'(P - 1)) ? '0 : next_idx + 1'b1;
      end
   end

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid && !y_ready |=> y_valid && $stable(y_data) && $stable(y_neuron));

   assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid |-> y_neuron == next_idx);

   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done && !iter_done |=> done);

   assert_done_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(y_valid && y_ready) && $past(y_neuron) == JW'(P - 1));

   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done && iter_done |=> ld_ready && !done);

   assert_load_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ready |-> !done && !y_valid);

endmodule

bind seg_proj_unit spu_checker #(.P(P), .JW(JW), .YW(YW)) u_spu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_ready  (ld_ready),
   .y_valid   (y_valid),
   .y_ready   (y_ready),
   .y_data    (y_data),
   .y_neuron  (y_neuron),
   .done      (done),
   .iter_done (iter_done)
);

// File: tb/tb_seg_proj_unit.sv
module tb_seg_proj_unit;

   localparam int Q = 4, B = 4, P = 4, DW = 16, YW = 16, FRAC = 12;
   localparam int JW = 2, KW = 2, N = Q * B;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ld_valid = 1'b0;
   logic            ld_ready;
   logic [Q*DW-1:0] ld_data = '0;
   logic            wr_en = 1'b0;
   logic [JW-1:0]   wr_neuron = '0;
   logic [KW-1:0]   wr_seg = '0;
   logic [Q*DW-1:0] wr_data = '0;
   logic            y_valid;
   logic            y_ready = 1'b0;
   logic [YW-1:0]   y_data;
   logic [JW-1:0]   y_neuron;
   logic            done;
   logic            iter_done = 1'b0;

   always #2 clk = ~clk;

   seg_proj_unit #(.Q(Q), .B(B), .P(P), .DW(DW), .YW(YW), .FRAC(FRAC)) dut (.*);

   int    n_chk = 0, n_fail = 0;
   longint cyc = 0;
   int    xv [N];
   int    wv [P][N];
   int    expy [P];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int ref_y(input int j);
      longint s = 0;
      for (int e = 0; e < N; e++) s += longint'(wv[j][e]) * longint'(xv[e]);
      s = (s + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return int'(s);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_neuron(input int j);
      for (int k = 0; k < B; k++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_neuron = JW'(j); wr_seg = KW'(k);
         for (int r = 0; r < Q; r++) wr_data[r*DW +: DW] = DW'(wv[j][k*Q+r]);
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_x();
      chk(ld_ready == 1'b1, "R6", "ld_ready before load", longint'(ld_ready), 1);
      for (int k = 0; k < B; k++) begin
         @(negedge clk);
         ld_valid = 1'b1;
         for (int r = 0; r < Q; r++) ld_data[r*DW +: DW] = DW'(xv[k*Q+r]);
      end
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic junk_load();
      for (int c = 0; c < 3; c++) begin
         ld_valid = 1'b1;
         ld_data  = {$urandom, $urandom};
         @(negedge clk);
         chk(ld_ready == 1'b0, "R6", "ld_ready during run", longint'(ld_ready), 0);
      end
      ld_valid = 1'b0;
   endtask

   task automatic consume(input bit slow, input bit upd, input string tag);
      int got = 0, idle = 0;
      longint last_cyc = 0;
      if (!slow) y_ready = 1'b1;
      while (got < P && idle < 2000) begin
         @(negedge clk);
         if (y_valid) begin
            chk($signed(y_data) == expy[got], tag, "y_data",
                longint'($signed(y_data)), expy[got]);
            chk(int'(y_neuron) == got, "R2", "y_neuron", longint'(y_neuron), got);
            if (!slow && got > 0)
               chk(cyc - last_cyc == B, "R10", "output spacing", cyc - last_cyc, B);
            last_cyc = cyc;
            if (slow) begin
               repeat ($urandom_range(1, 5)) begin
                  if (got == 1) iter_done = 1'b1;
                  @(negedge clk);
                  iter_done = 1'b0;
               end
               chk($signed(y_data) == expy[got], "R5", "y_data held",
                   longint'($signed(y_data)), expy[got]);
               y_ready = 1'b1;
               @(negedge clk);
               y_ready = 1'b0;
               if (upd) begin
                  for (int e = 0; e < N; e++) wv[got][e] = $urandom_range(0, 4094) - 2047;
                  write_neuron(got);
               end
            end
            got++;
         end else begin
            idle++;
         end
      end
      if (!slow) begin
         @(negedge clk);
         y_ready = 1'b0;
      end
      chk(got == P, "R2", "outputs delivered", got, P);
   endtask

   task automatic finish_iter();
      @(negedge clk);
      chk(done == 1'b1, "R8", "done after last", longint'(done), 1);
      chk(ld_ready == 1'b0, "R6", "ld_ready while done", longint'(ld_ready), 0);
      repeat (3) @(negedge clk);
      chk(done == 1'b1, "R8", "done held", longint'(done), 1);
      iter_done = 1'b1;
      @(negedge clk);
      iter_done = 1'b0;
      chk(done == 1'b0, "R8", "done released", longint'(done), 0);
      chk(ld_ready == 1'b1, "R8", "ld_ready after release", longint'(ld_ready), 1);
   endtask

   task automatic iteration(input bit slow, input bit upd, input bit junk, input string tag);
      for (int j = 0; j < P; j++) expy[j] = ref_y(j);
      load_x();
      if (junk) junk_load();
      consume(slow, upd, tag);
      finish_iter();
   endtask

   task automatic rand_x();
      for (int e = 0; e < N; e++) xv[e] = $urandom_range(0, 4094) - 2047;
   endtask

   task automatic write_all();
      for (int j = 0; j < P; j++) write_neuron(j);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ld_ready == 1'b1, "R9", "reset ld_ready", longint'(ld_ready), 1);
      chk(y_valid == 1'b0, "R9", "reset y_valid", longint'(y_valid), 0);
      chk(done == 1'b0, "R9", "reset done", longint'(done), 0);

      // R1 / R10: random data, free-running consumer
      rand_x();
      for (int j = 0; j < P; j++)
         for (int e = 0; e < N; e++) wv[j][e] = $urandom_range(0, 4094) - 2047;
      write_all();
      iteration(1'b0, 1'b0, 1'b0, "R1");

      // R7 / R6: stalls, weight write-back and stray loads during the run
      rand_x();
      iteration(1'b1, 1'b1, 1'b1, "R7");
      rand_x();
      iteration(1'b1, 1'b1, 1'b0, "R5");

      // R4: half-LSB rounding corners
      for (int e = 0; e < N; e++) xv[e] = 0;
      xv[0] = 1;
      for (int j = 0; j < P; j++)
         for (int e = 0; e < N; e++) wv[j][e] = 0;
      wv[0][0] = 2048; wv[1][0] = -2048; wv[2][0] = 2047; wv[3][0] = -2049;
      write_all();
      chk(ref_y(0) == 1 && ref_y(3) == -1, "R4", "bench model rounding", ref_y(0), 1);
      iteration(1'b0, 1'b0, 1'b0, "R4");

      // R3: saturation in both directions
      for (int e = 0; e < N; e++) begin
         xv[e] = 32767;
         wv[0][e] = 32767;
         wv[1][e] = -32768;
         wv[2][e] = (e % 2 == 0) ? 32767 : -32768;
         wv[3][e] = $urandom_range(0, 40) - 20;
      end
      write_all();
      iteration(1'b1, 1'b0, 1'b0, "R3");

      // R1: further random iterations in mixed modes
      for (int it = 0; it < 4; it++) begin
         rand_x();
         if (it == 0) begin
            for (int j = 0; j < P; j++)
               for (int e = 0; e < N; e++) wv[j][e] = $urandom_range(0, 4094) - 2047;
            write_all();
         end
         iteration(it[0], 1'b1, it[1], "R1");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule